// File: doc/BRIEF.md
# AHB-Lite Burst Address Generator

This block sits on the manager side of an AHB-Lite port. It turns one burst request into the cycle-by-cycle address-phase stream: the transfer address, the transfer type, the size and the burst code. A request carries a start address, a transfer size and a burst code. The block covers single transfers, fixed-length incrementing and wrapping bursts of 4, 8 or 16 beats, and undefined-length incrementing bursts. It computes each following address, wrapping inside the block that size times beat count defines. It inserts BUSY cycles whenever the local stall input is high, and it holds its outputs while the bus reports wait states.

Requests arrive on a valid/ready handshake. `req_ready` is high only on a cycle whose clock edge will start a new burst. That is the case when the bus is ready and no beat of the current burst is left to issue after the edge. A request sitting on `req_valid` is back-pressured until then, and its fields must stay stable while it waits. A request is consumed on the edge where `req_valid` and `req_ready` are both high. The start address must be aligned to the transfer size. A fixed-length incrementing request that would run past a 1 KB boundary is consumed but rejected: no beat is issued and `req_err` reports it.

Top module: `ahb_burst_seq`

## Requirements
- R1: A request is consumed on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a burst still has beats to issue after the coming edge. In the cycle after a request is consumed, `htrans` is NONSEQ (2'b10), `haddr` equals the start address, and `hsize`/`hburst` equal the requested values.
- R2: `htrans` is encoded 2'b00 IDLE, 2'b01 BUSY, 2'b10 NONSEQ, 2'b11 SEQ. `hburst` is encoded 3'b000 single, 3'b001 undefined-length incrementing, 3'b010/3'b011 wrap/increment of 4 beats, 3'b100/3'b101 of 8 beats, and 3'b110/3'b111 of 16 beats. A single transfer issues one NONSEQ beat, and a fixed burst issues one NONSEQ followed by beat count minus one SEQ beats.
- R3: In an incrementing burst, each SEQ beat address equals the previous beat address plus 2^hsize bytes.
- R4: In a wrapping burst, each beat address is the previous one plus 2^hsize, taken modulo a block of (beat count × 2^hsize) bytes. The bits above that block are kept (for example, 4 words from 0x34 give 0x34, 0x38, 0x3C, 0x30).
- R5: `hsize` and `hburst` stay constant for every beat of a burst, including BUSY cycles.
- R6: When `stall` is high on a ready edge and the burst has a further beat to issue, `htrans` becomes BUSY and `haddr` already shows that next beat. After `stall` drops, the beat is issued as SEQ at the same address. `stall` has no effect when no further beat remains.
- R7: On an edge where `hready` is low, `haddr`, `htrans`, `hsize` and `hburst` are held, and `req_ready` is low.
- R8: After the last beat, `htrans` returns to IDLE. If a new request is consumed on that same edge, the next cycle instead shows its NONSEQ beat.
- R9: A fixed-length incrementing request whose start offset within its 1 KB block plus beat count × 2^hsize exceeds 1024 is consumed without issuing any beat. `req_err` is high for exactly the following cycle, and `htrans` stays IDLE.
- R10: An undefined-length burst continues until `stop` is high on a ready edge that issues a beat, and that beat is the last. It also ends by itself after the beat at the last aligned address below a 1 KB boundary. `stop` wins over `stall` on the same edge.
- R11: While reset is active (`rst_n` low), `htrans` is IDLE, `haddr` is zero and `req_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Request will be consumed on this edge |
| req_addr | input | AW | Start address, aligned to the size |
| req_size | input | 3 | Transfer size, bytes = 2^req_size |
| req_burst | input | 3 | Burst code (encoding in R2) |
| stall | input | 1 | Insert a BUSY cycle before the next beat |
| stop | input | 1 | End an undefined-length burst |
| hready | input | 1 | Bus ready; outputs advance only when high |
| haddr | output | AW | Address-phase address |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | Transfer size of the current burst |
| hburst | output | 3 | Burst code of the current burst |
| req_err | output | 1 | One-cycle pulse: request rejected for crossing 1 KB |

## Verification
The two functions that meet in one cycle are the completion of a burst's last beat and the consumption of the next request. The bench provokes this by holding a new request on `req_valid` while the last SEQ beat of a 4-beat burst is on the bus. It judges that `req_ready` is high before that edge, and that the next cycle shows the new request's NONSEQ beat, address and size with no IDLE cycle in between. A second overlap, `stop` and `stall` on the same edge of an undefined-length burst, arises in the noisy sweep. There the bench expects IDLE rather than BUSY.

// File: rtl/ahb_seq_pkg.sv
package ahb_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BT_SINGLE = 3'b000;
  localparam logic [2:0] BT_UNDEF  = 3'b001;

endpackage

// File: rtl/ahb_burst_decode.sv
module ahb_burst_decode
  import ahb_seq_pkg::*;
(
  input  logic [2:0] burst,
  output logic [2:0] beats_log2,
  output logic       is_wrap,
  output logic       is_undef
);

  always_comb begin
    unique case (burst[2:1])
      2'b01:   beats_log2 = 3'd2;
      2'b10:   beats_log2 = 3'd3;
      2'b11:   beats_log2 = 3'd4;
      default: beats_log2 = 3'd0;
    endcase
  end

  assign is_undef = (burst == BT_UNDEF);
  assign is_wrap  = (burst != BT_SINGLE) && !burst[0];

endmodule

// File: rtl/ahb_addr_next.sv
module ahb_addr_next #(
  parameter int AW      = 32,
  parameter int BOUND_W = 10
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    size,
  input  logic [2:0]    beats_log2,
  input  logic          is_wrap,
  output logic [AW-1:0] nxt,
  output logic          at_bound
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0]    step;
  logic [AW-1:0]    inc;
  logic [AW-1:0]    mask;
  logic [3:0]       span_log2;
  logic [BOUND_W:0] low_sum;

  assign step      = ONE << size;
  assign inc       = cur + step;
  assign span_log2 = {1'b0, size} + {1'b0, beats_log2};
  assign mask      = (ONE << span_log2) - ONE;
  assign nxt       = is_wrap ? ((cur & ~mask) | (inc & mask)) : inc;

  // carry out of the low address bits marks the last beat before a boundary
  assign low_sum  = {1'b0, cur[BOUND_W-1:0]} + step[BOUND_W:0];
  assign at_bound = low_sum[BOUND_W];

endmodule

// File: rtl/ahb_kb_guard.sv
module ahb_kb_guard #(
  parameter int BOUND_W = 10
) (
  input  logic [BOUND_W-1:0] start_low,
  input  logic [2:0]         size,
  input  logic [2:0]         beats_log2,
  input  logic               check_en,
  output logic               crosses
);

  localparam int SW = BOUND_W + 2;
  localparam logic [SW-1:0] ONE   = SW'(1);
  localparam logic [SW-1:0] LIMIT = ONE << BOUND_W;

  logic [SW-1:0] span;
  logic [SW-1:0] sum;

  assign span    = ONE << ({1'b0, size} + {1'b0, beats_log2});
  assign sum     = {2'b00, start_low} + span;
  assign crosses = check_en && (sum > LIMIT);

endmodule

// File: rtl/ahb_burst_seq.sv
module ahb_burst_seq
  import ahb_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BOUND_W   = 10,
  parameter int MAX_LOG2  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [2:0]    req_burst,
  input  logic          stall,
  input  logic          stop,
  input  logic          hready,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic          req_err
);

  localparam int CNT_W = MAX_LOG2;

  trans_e           trans_q;
  logic [AW-1:0]    addr_q;
  logic [2:0]       size_q;
  logic [2:0]       burst_q;
  logic [CNT_W-1:0] rem_q;
  logic             err_q;

  logic [2:0]       cur_log2, req_log2;
  logic             cur_wrap, cur_undef, req_wrap, req_undef;
  logic [AW-1:0]    next_addr;
  logic             at_bound;
  logic             bad_req;
  logic             busy_now, xfer_now, cont, accept;
  logic [CNT_W-1:0] rem_load;

  ahb_burst_decode u_cur_dec (
    .burst(burst_q), .beats_log2(cur_log2), .is_wrap(cur_wrap), .is_undef(cur_undef)
  );

  ahb_burst_decode u_req_dec (
    .burst(req_burst), .beats_log2(req_log2), .is_wrap(req_wrap), .is_undef(req_undef)
  );

  ahb_addr_next #(.AW(AW), .BOUND_W(BOUND_W)) u_next (
    .cur(addr_q), .size(size_q), .beats_log2(cur_log2), .is_wrap(cur_wrap),
    .nxt(next_addr), .at_bound(at_bound)
  );

  ahb_kb_guard #(.BOUND_W(BOUND_W)) u_guard (
    .start_low(req_addr[BOUND_W-1:0]), .size(req_size), .beats_log2(req_log2),
    .check_en(!req_wrap && !req_undef && (req_log2 != 3'd0)),
    .crosses(bad_req)
  );

  assign busy_now = (trans_q == TR_BUSY);
  assign xfer_now = trans_q[1];

  // does the current burst still own the address phase after this edge?
  always_comb begin
    if (cur_undef)
      cont = !stop && (busy_now || (xfer_now && !at_bound));
    else
      cont = busy_now || (xfer_now && (rem_q != '0));
  end

  assign req_ready = hready && !cont;
  assign accept    = req_valid && req_ready;
  assign rem_load  = ~({CNT_W{1'b1}} << req_log2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      burst_q <= '0;
      rem_q   <= '0;
    end else if (hready) begin
      if (cont) begin
        trans_q <= stall ? TR_BUSY : TR_SEQ;
        if (xfer_now) addr_q <= next_addr;
        if (!stall && !cur_undef) rem_q <= rem_q - 1'b1;
      end else if (accept && !bad_req) begin
        trans_q <= TR_NONSEQ;
        addr_q  <= req_addr;
        size_q  <= req_size;
        burst_q <= req_burst;
        rem_q   <= rem_load;
      end else begin
        trans_q <= TR_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept && bad_req;
  end

  assign haddr   = addr_q;
  assign htrans  = trans_q;
  assign hsize   = size_q;
  assign hburst  = burst_q;
  assign req_err = err_q;

endmodule

// File: rtl/ahb_burst_seq_chk.sv
module ahb_burst_seq_chk #(
  parameter int AW      = 32,
  parameter int BOUND_W = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hready,
  input logic          req_ready,
  input logic          req_err,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic [2:0]    hsize,
  input logic [2:0]    hburst
);

  localparam logic [AW-1:0] ONE = AW'(1);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(haddr) && $stable(htrans) && $stable(hsize) && $stable(hburst)));

  // R7
  ready_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> hready);

  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11 && hburst[0] && $past(hready) && $past(htrans[1]))
      |-> haddr == $past(haddr) + (ONE << hsize));

  // R5
  size_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11 || htrans == 2'b01) |-> ($stable(hsize) && $stable(hburst)));

  // R6
  busy_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b01 |-> ($past(htrans) != 2'b00 && hburst != 3'b000));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (htrans == 2'b00 && !$past(req_err)));

  // R10
  no_kb_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b11 |-> haddr[AW-1:BOUND_W] == $past(haddr[AW-1:BOUND_W]));

  // R2
  single_one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hburst == 3'b000 |-> !htrans[0]);

endmodule

bind ahb_burst_seq ahb_burst_seq_chk #(.AW(AW), .BOUND_W(BOUND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hready(hready), .req_ready(req_ready), .req_err(req_err),
  .haddr(haddr), .htrans(htrans), .hsize(hsize), .hburst(hburst)
);

// File: tb/ahb_burst_seq_test.sv
`timescale 1ns/1ps
module ahb_burst_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [2:0]  req_burst = '0;
  logic        stall = 1'b0;
  logic        stop = 1'b0;
  logic        hready = 1'b1;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic        req_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  ahb_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_burst(req_burst),
    .stall(stall), .stop(stop), .hready(hready),
    .haddr(haddr), .htrans(htrans), .hsize(hsize), .hburst(hburst), .req_err(req_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // one request, modelled beat by beat from the requirements
  task automatic run(input logic [31:0] base, input int sz, input int bt, input int un, input bit noisy);
    int step, lg, n, k, edge_beats;
    bit wrap, capped, bad, hr, st, held;
    logic [1:0] mt;
    logic [31:0] a, mask, ea;
    string tag;
    step = 1 << sz;
    a = base & ~(32'(step) - 32'd1);
    lg = (bt >= 6) ? 4 : (bt >= 4) ? 3 : (bt >= 2) ? 2 : 0;
    wrap = (bt != 0) && (bt % 2 == 0);
    capped = 1'b0;
    if (bt == 0) n = 1;
    else if (bt == 1) begin
      n = un;
      edge_beats = (1024 - int'(a % 1024)) / step;
      if (n > edge_beats) begin n = edge_beats; capped = 1'b1; end
    end else n = 1 << lg;
    bad = (bt % 2 == 1) && (bt != 1) && (int'(a % 1024) + n * step > 1024);
    mask = 32'(n * step) - 32'd1;

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 3'(sz); req_burst = 3'(bt);
    hready = 1'b1; stall = 1'b0; stop = 1'b0;
    chk(req_ready === 1'b1, "R1 ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(req_err === 1'b1, "R9 err pulse", 32'(req_err), 32'd1);
      chk(htrans === 2'b00, "R9 no beat", 32'(htrans), 32'd0);
      @(negedge clk);
      chk(req_err === 1'b0, "R9 err one cycle", 32'(req_err), 32'd0);
      chk(htrans === 2'b00, "R9 still idle", 32'(htrans), 32'd0);
      return;
    end
    chk(req_err === 1'b0, "R9 no err", 32'(req_err), 32'd0);
    mt = 2'b10; k = 0; held = 1'b0;
    forever begin
      if (held) tag = "R7";
      else if (mt == 2'b01) tag = "R6";
      else if (mt == 2'b00) tag = (bt == 1) ? "R10" : "R8";
      else tag = "R2";
      chk(htrans === mt, tag, 32'(htrans), 32'(mt));
      if (mt == 2'b00) break;
      ea = wrap ? ((a & ~mask) | ((a + 32'(k * step)) & mask)) : a + 32'(k * step);
      chk(haddr === ea, wrap ? "R4" : (k == 0 ? "R1" : "R3"), haddr, ea);
      chk(hsize === 3'(sz) && hburst === 3'(bt), "R5", {26'd0, hsize, hburst}, 32'((sz << 3) | bt));
      step_lfsr();
      hr = noisy ? (lfsr[1:0] != 2'b00) : 1'b1;
      st = noisy ? (lfsr[3:2] == 2'b00) : 1'b0;
      hready = hr;
      stall = st;
      stop = (bt == 1) && mt[1] && (k == n - 1) && !capped;
      held = !hr;
      if (hr) begin
        if (mt[1]) begin
          if (k + 1 < n) begin k++; mt = st ? 2'b01 : 2'b11; end
          else mt = 2'b00;
        end else mt = st ? 2'b01 : 2'b11;
      end
      @(negedge clk);
    end
    stop = 1'b0; stall = 1'b0; hready = 1'b1;
  endtask

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_1034;
    bases[1] = 32'h4000_03F0;
    bases[2] = 32'h0002_07FC;

    repeat (3) @(negedge clk);
    // R11
    chk(htrans === 2'b00, "R11 htrans in reset", 32'(htrans), 32'd0);
    chk(haddr === 32'd0, "R11 haddr in reset", haddr, 32'd0);
    chk(req_err === 1'b0, "R11 err in reset", 32'(req_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(htrans === 2'b00, "R11 idle after reset", 32'(htrans), 32'd0);

    // back-to-back: last beat and next request on one edge
    req_valid = 1'b1; req_addr = 32'h100; req_size = 3'd2; req_burst = 3'b011;
    @(negedge clk);
    req_valid = 1'b0;
    chk(htrans === 2'b10 && haddr === 32'h100, "R1 nonseq start", haddr, 32'h100);
    hready = 1'b0;
    chk(req_ready === 1'b0, "R7 ready low in wait", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(htrans === 2'b10 && haddr === 32'h100, "R7 held in wait", haddr, 32'h100);
    hready = 1'b1;
    chk(req_ready === 1'b0, "R1 ready low mid burst", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(htrans === 2'b11 && haddr === 32'h104, "R3 beat 1", haddr, 32'h104);
    @(negedge clk);
    chk(haddr === 32'h108, "R3 beat 2", haddr, 32'h108);
    @(negedge clk);
    chk(htrans === 2'b11 && haddr === 32'h10C, "R3 beat 3", haddr, 32'h10C);
    req_valid = 1'b1; req_addr = 32'h201; req_size = 3'd0; req_burst = 3'b000;
    chk(req_ready === 1'b1, "R8 ready on last beat", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(htrans === 2'b10, "R8 back-to-back nonseq", 32'(htrans), 32'd2);
    chk(haddr === 32'h201, "R8 back-to-back addr", haddr, 32'h201);
    chk(hsize === 3'd0 && hburst === 3'd0, "R5 new size", {29'd0, hsize}, 32'd0);
    @(negedge clk);
    chk(htrans === 2'b00, "R8 idle after single", 32'(htrans), 32'd0);

    // sweep every burst code, size and base, clean then noisy
    for (int nz = 0; nz < 2; nz++)
      for (int bt = 0; bt < 8; bt++)
        for (int sz = 0; sz < 3; sz++)
          for (int bi = 0; bi < 3; bi++)
            run(bases[bi], sz, bt, 5 + bi, nz[0]);

    // long undefined-length burst that meets a 1 KB boundary (R10)
    run(32'h0000_0380, 2, 1, 100, 1'b0);
    run(32'h0000_0380, 2, 1, 100, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule